// File: doc/BRIEF.md
# PCI Interrupt Map and Gate

This block sits between the interrupt levels reported by PCI functions and the interrupt inputs of the system interrupt controller. It keeps one level per interrupt number (32 by default) and drives one output per number. Numbers are gathered in groups of four. Each group has a mapping register, and the top bit of that register opens or closes the group's gate. A closed gate holds all four outputs low, whatever levels are stored behind it.

Level changes arrive as events. Each event carries an interrupt number and a level. The number comes from a small combinational calculator that turns a device/function code and an interrupt pin into a number. It handles two bus kinds: the primary bus and a secondary bridge bus. Software reads and writes the mapping registers through a simple word-addressed register port. Only the gate bit of each mapping register is writable. The remaining bits are a fixed descriptor of the group.

Top module: `pci_irq_map_gate`

## Requirements
- R1: While `rst_n` is low, and after it rises, every `irq_out` bit is 0 and every gate bit reads 0. Mapping register g reads with bits 30:0 equal to (0x1F << 6) | (4·g).
- R2: A write to the upper word of register g (offset 0xC00 + 8·g + 4) copies `wr_data[31]` into the gate bit. Bits 30:0 keep reading (0x1F << 6) | (4·g), whatever value was written.
- R3: The gate bit of group n>>2 is set one clock edge before `irq_out[n]` is sampled. In that case `irq_out[n]` equals the level held for number n one edge earlier. Each output is therefore registered once behind the stored level and the gate bit.
- R4: While the gate bit of group n>>2 is clear, `irq_out[n]` is 0, whatever level is stored for n.
- R5: With `bus_bridge` = 0 (primary bus), `irq_number` equals `pin` + 16 when `devfn[0]` is 1, and equals `pin` when `devfn[0]` is 0.
- R6: With `bus_bridge` = 1 (secondary bridge bus), `irq_number` equals 4·`devfn[4:3]` + `pin`.
- R7: Reading the lower word of any mapping register (offset bit 2 = 0) returns 0. Writing the lower word changes no gate bit.
- R8: Reading offsets outside 0xC00..0xC3F returns 0. Writing there changes no gate bit.
- R9: A level event with `ev_num` ≥ 32 changes no stored level and no output.
- R10: A level event with `ev_num` < 32 stores `ev_level` for that number only. The stored level persists until another event for that number or a reset, and a reset clears all stored levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 16 | Register byte offset |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data, combinational from `reg_addr` |
| ev_we | input | 1 | Level event strobe |
| ev_num | input | 6 | Interrupt number of the event |
| ev_level | input | 1 | New level for that number |
| bus_bridge | input | 1 | 0 selects the primary-bus formula, 1 the bridge formula |
| devfn | input | 8 | Device/function code |
| pin | input | 2 | Interrupt pin index, 0 to 3 |
| irq_number | output | 5 | Computed interrupt number |
| irq_out | output | 32 | Gated interrupt levels |

## Verification
On every cycle the assertions check four things:
- the reset values of the outputs and the gate bits;
- that no output is high one edge after its group's gate was closed, and that each output follows the stored level and gate bit of the edge before;
- that writes to lower words and events with out-of-range numbers leave state untouched;
- that the number calculator keeps the pin in the low bits and puts the half bit (primary bus) or the range below 16 (bridge bus) in the right place.

Other behaviours only the bench's scenarios show:
- the exact read-back values of bits 30:0;
- that out-of-window accesses are harmless;
- that no aliasing exists between numbers 32..63 and 0..31;
- that levels stored while a gate is closed appear once the gate opens.

The bench also sweeps the calculator over every bus kind, device/function code and pin.

// File: rtl/pim_pkg.sv
package pim_pkg;

   // Fixed descriptor held in bits 30:0 of a mapping register
   function automatic logic [30:0] desc_bits(input int unsigned grp, input int unsigned per_grp);
      logic [30:0] v;
      v = (31'h1f << 6) | 31'(grp * per_grp);
      return v;
   endfunction

   typedef enum logic {
      BUS_PRIMARY = 1'b0,
      BUS_BRIDGE  = 1'b1
   } bus_kind_e;

endpackage

// File: rtl/pim_regs.sv
module pim_regs #(
   parameter int unsigned NUM_GROUPS = 8,
   parameter int unsigned PER_GROUP  = 4,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned WIN_BASE   = 'hC00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic                  gate_wbit,
   output logic [31:0]           rd_data,
   output logic [NUM_GROUPS-1:0] gate_q
);
   import pim_pkg::*;

   localparam int unsigned GRP_W   = $clog2(NUM_GROUPS);
   localparam int unsigned STRIDE  = 8;
   localparam int unsigned WIN_END = WIN_BASE + NUM_GROUPS * STRIDE;

   logic              in_win;
   logic              upper;
   logic [GRP_W-1:0]  grp_idx;
   logic [ADDR_W-1:0] rel;

   always_comb begin
      in_win  = (reg_addr >= ADDR_W'(WIN_BASE)) && (reg_addr < ADDR_W'(WIN_END));
      upper   = reg_addr[2];
      rel     = reg_addr - ADDR_W'(WIN_BASE);
      grp_idx = GRP_W'(rel >> 3);
   end

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_gate
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               gate_q[g] <= 1'b0;
            else if (wr_en && in_win && upper && (grp_idx == GRP_W'(g)))
               gate_q[g] <= gate_wbit;
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (in_win && upper && (grp_idx == GRP_W'(g)))
            rd_data = {gate_q[g], desc_bits(g, PER_GROUP)};
      end
   end

endmodule

// File: rtl/pim_irq_num.sv
module pim_irq_num #(
   parameter int unsigned NUM_LINES = 32
) (
   input  logic                          bus_bridge,
   input  logic [7:0]                    devfn,
   input  logic [1:0]                    pin,
   output logic [$clog2(NUM_LINES)-1:0]  irq_number
);
   import pim_pkg::*;

   localparam int unsigned IDX_W    = $clog2(NUM_LINES);
   localparam int unsigned HALF_OFS = NUM_LINES / 2;

   bus_kind_e kind;

   always_comb begin
      kind = bus_kind_e'(bus_bridge);
      case (kind)
         BUS_BRIDGE:  irq_number = IDX_W'({devfn[4:3], pin});
         default:     irq_number = IDX_W'(pin) + (devfn[0] ? IDX_W'(HALF_OFS) : '0);
      endcase
   end

endmodule

// File: rtl/pim_gate.sv
module pim_gate #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned PER_GROUP = 4,
   parameter int unsigned NUM_W     = 6
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             ev_we,
   input  logic [NUM_W-1:0]                 ev_num,
   input  logic                             ev_level,
   input  logic [NUM_LINES/PER_GROUP-1:0]   gate_q,
   output logic [NUM_LINES-1:0]             lvl_q,
   output logic [NUM_LINES-1:0]             irq_out
);
   generate
      for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl_q[n]   <= 1'b0;
               irq_out[n] <= 1'b0;
            end else begin
               if (ev_we && (ev_num == NUM_W'(n)))
                  lvl_q[n] <= ev_level;
               irq_out[n] <= lvl_q[n] & gate_q[n / PER_GROUP];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pci_irq_map_gate.sv
module pci_irq_map_gate #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned PER_GROUP = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned WIN_BASE  = 'hC00
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic [31:0]                   wr_data,
   output logic [31:0]                   rd_data,
   input  logic                          ev_we,
   input  logic [$clog2(NUM_LINES):0]    ev_num,
   input  logic                          ev_level,
   input  logic                          bus_bridge,
   input  logic [7:0]                    devfn,
   input  logic [1:0]                    pin,
   output logic [$clog2(NUM_LINES)-1:0]  irq_number,
   output logic [NUM_LINES-1:0]          irq_out
);
   localparam int unsigned NUM_GROUPS = NUM_LINES / PER_GROUP;
   localparam int unsigned NUM_W      = $clog2(NUM_LINES) + 1;

   generate
      if (NUM_LINES % PER_GROUP != 0) begin : g_bad_split
         $error("NUM_LINES must be a multiple of PER_GROUP");
      end
      if (PER_GROUP != 4) begin : g_bad_group
         $error("bridge formula assumes four pins per group");
      end
      if (NUM_GROUPS < 2 || NUM_GROUPS > 8) begin : g_bad_groups
         $error("NUM_GROUPS must lie in 2..8");
      end
      if ((WIN_BASE % 64) != 0) begin : g_bad_base
         $error("WIN_BASE must be 64-byte aligned");
      end
   endgenerate

   logic [NUM_GROUPS-1:0] gate_q;
   logic [NUM_LINES-1:0]  lvl_q;

   pim_regs #(
      .NUM_GROUPS (NUM_GROUPS),
      .PER_GROUP  (PER_GROUP),
      .ADDR_W     (ADDR_W),
      .WIN_BASE   (WIN_BASE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .reg_addr  (reg_addr),
      .gate_wbit (wr_data[31]),
      .rd_data   (rd_data),
      .gate_q    (gate_q)
   );

   pim_gate #(
      .NUM_LINES (NUM_LINES),
      .PER_GROUP (PER_GROUP),
      .NUM_W     (NUM_W)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_we    (ev_we),
      .ev_num   (ev_num),
      .ev_level (ev_level),
      .gate_q   (gate_q),
      .lvl_q    (lvl_q),
      .irq_out  (irq_out)
   );

   pim_irq_num #(
      .NUM_LINES (NUM_LINES)
   ) u_num (
      .bus_bridge (bus_bridge),
      .devfn      (devfn),
      .pin        (pin),
      .irq_number (irq_number)
   );

endmodule

// File: rtl/pim_checker.sv
module pim_checker #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned PER_GROUP = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned WIN_BASE  = 'hC00
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic                                 wr_en,
   input logic [ADDR_W-1:0]                    reg_addr,
   input logic [31:0]                          wr_data,
   input logic                                 ev_we,
   input logic [$clog2(NUM_LINES):0]           ev_num,
   input logic                                 bus_bridge,
   input logic [7:0]                           devfn,
   input logic [1:0]                           pin,
   input logic [$clog2(NUM_LINES)-1:0]         irq_number,
   input logic [NUM_LINES-1:0]                 irq_out,
   input logic [NUM_LINES/PER_GROUP-1:0]       gate_q,
   input logic [NUM_LINES-1:0]                 lvl_q
);
   localparam int unsigned NUM_GROUPS = NUM_LINES / PER_GROUP;
   localparam int unsigned GRP_W      = $clog2(NUM_GROUPS);
   localparam int unsigned IDX_W      = $clog2(NUM_LINES);

   logic [NUM_LINES-1:0] gate_lines;
   logic                 hit_upper;
   logic [GRP_W-1:0]     hit_grp;
   logic [ADDR_W-1:0]    ofs;

   always_comb begin
      for (int n = 0; n < NUM_LINES; n++)
         gate_lines[n] = gate_q[n / PER_GROUP];
      ofs       = reg_addr - ADDR_W'(WIN_BASE);
      hit_upper = (ofs < ADDR_W'(NUM_GROUPS * 8)) && (reg_addr >= ADDR_W'(WIN_BASE)) && reg_addr[2];
      hit_grp   = GRP_W'(ofs >> 3);
   end

   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (gate_q == '0 && irq_out == '0));

   p_gate_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_upper) |=> gate_q[$past(hit_grp)] == $past(wr_data[31]));

   p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_out == ($past(lvl_q) & $past(gate_lines)));

   p_closed_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_out & ~$past(gate_lines)) == '0);

   p_primary_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_bridge |-> (irq_number[IDX_W-1] == devfn[0] && irq_number[1:0] == pin));

   p_bridge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_bridge |-> (irq_number[IDX_W-1] == 1'b0 && irq_number[1:0] == pin));

   p_low_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !reg_addr[2]) |=> $stable(gate_q));

   p_num_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_we && ev_num >= (IDX_W+1)'(NUM_LINES)) |=> $stable(lvl_q));

endmodule

bind pci_irq_map_gate pim_checker #(
   .NUM_LINES (NUM_LINES),
   .PER_GROUP (PER_GROUP),
   .ADDR_W    (ADDR_W),
   .WIN_BASE  (WIN_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .reg_addr   (reg_addr),
   .wr_data    (wr_data),
   .ev_we      (ev_we),
   .ev_num     (ev_num),
   .bus_bridge (bus_bridge),
   .devfn      (devfn),
   .pin        (pin),
   .irq_number (irq_number),
   .irq_out    (irq_out),
   .gate_q     (gate_q),
   .lvl_q      (lvl_q)
);

// File: tb/pci_irq_map_gate_bench.sv
module pci_irq_map_gate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        ev_we = 1'b0;
   logic [5:0]  ev_num = '0;
   logic        ev_level = 1'b0;
   logic        bus_bridge = 1'b0;
   logic [7:0]  devfn = '0;
   logic [1:0]  pin = '0;
   logic [4:0]  irq_number;
   logic [31:0] irq_out;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [31:0] m_lvl;
   logic [7:0]  m_gate;

   always #4 clk = ~clk;

   pci_irq_map_gate u_pci_irq_map_gate (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
      .wr_data(wr_data), .rd_data(rd_data), .ev_we(ev_we), .ev_num(ev_num),
      .ev_level(ev_level), .bus_bridge(bus_bridge), .devfn(devfn), .pin(pin),
      .irq_number(irq_number), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_out();
      logic [31:0] m;
      for (int n = 0; n < 32; n++) m[n] = m_lvl[n] & m_gate[n / 4];
      return m;
   endfunction

   function automatic logic [31:0] exp_reg(input int g);
      return {m_gate[g], 31'((32'h1f << 6) | (g * 4))};
   endfunction

   task automatic settle();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic reg_wr(input logic [15:0] a, input logic [31:0] d);
      reg_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input string req, input logic [15:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   task automatic ev(input logic [5:0] num, input logic lv);
      ev_num = num; ev_level = lv; ev_we = 1'b1;
      @(negedge clk);
      ev_we = 1'b0;
   endtask

   task automatic set_gate(input int g, input logic v);
      reg_wr(16'hC00 + 16'(g * 8 + 4), {v, 31'h7fffffff});
      m_gate[g] = v;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      m_lvl = '0; m_gate = '0;
      chk("R1 during reset", irq_out, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_lvl = '0; m_gate = '0;
      @(negedge clk); @(negedge clk);
      do_reset();
      // R1: reset values
      chk("R1 outputs", irq_out, 32'h0);
      for (int g = 0; g < 8; g++) reg_rd("R1 reg", 16'hC04 + 16'(g * 8), exp_reg(g));

      // R5 R6: full sweep of the number calculator
      for (int b = 0; b < 2; b++)
         for (int d = 0; d < 256; d++)
            for (int p = 0; p < 4; p++) begin
               bus_bridge = b[0]; devfn = d[7:0]; pin = p[1:0];
               #1;
               if (b == 0) chk("R5 primary", 32'(irq_number), 32'(p + (d[0] ? 16 : 0)));
               else        chk("R6 bridge", 32'(irq_number), 32'(((d & 'h18) >> 1) + p));
            end

      // R2: only bit 31 writable
      for (int g = 0; g < 8; g++) set_gate(g, (g % 2) == 0);
      for (int g = 0; g < 8; g++) reg_rd("R2 readback", 16'hC04 + 16'(g * 8), exp_reg(g));
      reg_wr(16'hC0C, 32'h0000_0000);
      reg_rd("R2 ro bits after zero write", 16'hC0C, exp_reg(1));

      // R7: lower words
      for (int g = 0; g < 8; g++) reg_wr(16'hC00 + 16'(g * 8), 32'hFFFF_FFFF);
      for (int g = 0; g < 8; g++) begin
         reg_rd("R7 low word reads zero", 16'hC00 + 16'(g * 8), 32'h0);
         reg_rd("R7 gate untouched", 16'hC04 + 16'(g * 8), exp_reg(g));
      end

      // R8: outside the window
      reg_wr(16'hC44, 32'hFFFF_FFFF);
      reg_wr(16'hBFC, 32'hFFFF_FFFF);
      reg_wr(16'h0C04 + 16'h1000, 32'hFFFF_FFFF);
      reg_rd("R8 read above", 16'hC44, 32'h0);
      reg_rd("R8 read below", 16'hBFC, 32'h0);
      for (int g = 0; g < 8; g++) reg_rd("R8 gate untouched", 16'hC04 + 16'(g * 8), exp_reg(g));

      // R3 R4 R10: walk each line up with alternating gates
      for (int n = 0; n < 32; n++) begin
         ev(6'(n), 1'b1); m_lvl[n] = 1'b1;
         settle();
         chk("R3 R4 R10 walk up", irq_out, exp_out());
      end
      chk("R4 closed groups low", irq_out, 32'h0F0F_0F0F);
      for (int n = 0; n < 32; n += 3) begin
         ev(6'(n), 1'b0); m_lvl[n] = 1'b0;
         settle();
         chk("R10 single line cleared", irq_out, exp_out());
      end
      // R3: opening gates reveals stored levels
      for (int g = 0; g < 8; g++) begin
         set_gate(g, 1'b1);
         settle();
         chk("R3 gate opened", irq_out, exp_out());
      end
      set_gate(3, 1'b0);
      settle();
      chk("R4 gate closed", irq_out, exp_out());
      set_gate(3, 1'b1);

      // R9: out-of-range numbers ignored
      for (int n = 0; n < 32; n++) begin ev(6'(n), 1'b1); m_lvl[n] = 1'b1; end
      settle();
      chk("R9 all high", irq_out, 32'hFFFF_FFFF);
      for (int n = 32; n < 64; n++) begin
         ev(6'(n), 1'b0);
         settle();
         chk("R9 ignored number", irq_out, 32'hFFFF_FFFF);
      end

      // R1 R10: reset in the middle of operation
      do_reset();
      chk("R1 after mid reset", irq_out, 32'h0);
      for (int g = 0; g < 8; g++) reg_rd("R1 gate cleared", 16'hC04 + 16'(g * 8), exp_reg(g));
      for (int g = 0; g < 8; g++) set_gate(g, 1'b1);
      settle();
      chk("R10 levels cleared by reset", irq_out, 32'h0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule